// File: doc/BRIEF.md
# Operand Address Resolver

This block works out the 16-bit effective address of one instruction for an 8-bit processor with 16-bit addressing. The sequencer gives it the addressing mode, the program counter that points just past the opcode, and the two index registers, then pulses `start`. The resolver fetches operand bytes from successive program-counter locations. For the indirect modes it then fetches pointer bytes from memory. It makes at most one read per cycle.

When it has the result it raises `done` for one cycle. At that point `ea` holds the effective address and `pc_out` holds the program counter advanced past the operand bytes. Both outputs keep their values until the next start is accepted. Memory answers combinationally: `rd_data` must be valid in the same cycle that `rd_en` and `rd_addr` are presented.

The address arithmetic follows the wrap rules of the target processor, not plain linear addition:

- Zero-page sums stay inside page zero.
- The indirect-jump pointer never carries into its page byte.
- Branch offsets are signed.

Top module: `addr_resolver`

## Requirements
- R1: While reset is low and in the cycle after it is released, `ea` and `pc_out` are 0x0000, and `done` and `rd_en` are low.
- R2: The modes are coded as follows: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page + X, 5 zero page + Y, 6 absolute, 7 absolute + X, 8 absolute + Y, 9 pre-indexed indirect (X), 10 post-indexed indirect (Y), 11 absolute indirect, 12 relative. Codes 0, 1 and 13 to 15 make no read, give `ea` = 0x0000 and leave the program counter unchanged.
- R3: Immediate mode (2) makes no read, gives `ea` equal to the incoming PC, and gives `pc_out` = PC + 1.
- R4: Zero-page modes (3, 4, 5) read one byte at PC. `ea` = {0x00, (byte + index) mod 256}, where the index is 0, X or Y. `pc_out` = PC + 1.
- R5: Absolute modes (6, 7, 8) read the low byte at PC, then the high byte at PC + 1. `ea` = ({high, low} + index) mod 65536, where the index is 0, X or Y. `pc_out` = (PC + 2) mod 65536.
- R6: Pre-indexed mode (9) reads operand byte b at PC, then reads the target low byte at {0x00, (b + X) mod 256} and the target high byte at {0x00, (b + X + 1) mod 256}. `pc_out` = PC + 1.
- R7: Post-indexed mode (10) reads operand byte b at PC, then reads the low byte at {0x00, b} and the high byte at {0x00, (b + 1) mod 256}. `ea` = ({high, low} + Y) mod 65536.
- R8: Absolute indirect mode (11) reads pointer bytes lo and hi at PC and PC + 1. It then reads the target low byte at {hi, lo} and the target high byte at {hi, (lo + 1) mod 256}. `pc_out` = PC + 2.
- R9: Relative mode (12) reads offset byte o at PC. `ea` = (PC + 1 + sign-extended o) mod 65536, and `pc_out` = PC + 1.
- R10: `rd_en` is high only in the cycles that make a read, with one read per cycle. `done` is high for exactly one cycle, that cycle is the (n+1)-th cycle after the clock edge that accepted `start` (n reads), and `rd_en` is low while `done` is high.
- R11: `start` is accepted only when the block is idle. A start that is high during reads or during the `done` cycle causes no read and no change. `ea` and `pc_out` hold from `done` until the next accepted start, whatever the other inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution; accepted only when idle |
| mode | input | 4 | Addressing mode code (see R2) |
| pc_in | input | 16 | Program counter just past the opcode |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_data | input | 8 | Read data, valid in the same cycle as the read |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | 16 | Read address |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter advanced past the operand |
| done | output | 1 | One-cycle completion pulse |

## Verification
A new `start` can coincide with the `done` cycle of the previous resolution, or with any of its read cycles. The bench provokes this by holding `start` high, with a different mode and PC, from the accepting edge through the `done` cycle. It then judges that the read addresses still follow the first request. It also checks that no read follows `done`, and that `ea` and `pc_out` still hold the first result one cycle later.

// File: rtl/ares_pkg.sv
package ares_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 4;
  localparam int PAGE_W = ADDR_W - BYTE_W;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL   = 4'd0,
    AM_ACCU   = 4'd1,
    AM_IMMED  = 4'd2,
    AM_ZPG    = 4'd3,
    AM_ZPG_X  = 4'd4,
    AM_ZPG_Y  = 4'd5,
    AM_ABS    = 4'd6,
    AM_ABS_X  = 4'd7,
    AM_ABS_Y  = 4'd8,
    AM_PRE_X  = 4'd9,
    AM_POST_Y = 4'd10,
    AM_IND    = 4'd11,
    AM_REL    = 4'd12
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPLO,
    ST_OPHI,
    ST_PLO,
    ST_PHI,
    ST_FIN
  } step_e;

  // byte sum that wraps inside one page
  function automatic logic [BYTE_W-1:0] zp_wrap(input logic [BYTE_W-1:0] b,
                                                input logic [BYTE_W-1:0] i);
    return b + i;
  endfunction

  function automatic logic [ADDR_W-1:0] in_page0(input logic [BYTE_W-1:0] b);
    return {{PAGE_W{1'b0}}, b};
  endfunction

  // full-width index add, carry into the page byte
  function automatic logic [ADDR_W-1:0] idx_wide(input logic [ADDR_W-1:0] base,
                                                 input logic [BYTE_W-1:0] i);
    return base + in_page0(i);
  endfunction

  function automatic logic [ADDR_W-1:0] rel_dest(input logic [ADDR_W-1:0] pc,
                                                 input logic [BYTE_W-1:0] off);
    return pc + {{PAGE_W{off[BYTE_W-1]}}, off};
  endfunction

  // next byte within the same page (no carry)
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:BYTE_W], p[BYTE_W-1:0] + BYTE_W'(1)};
  endfunction

  function automatic logic no_read(input logic [MODE_W-1:0] m);
    return (m inside {AM_IMPL, AM_ACCU, AM_IMMED}) || (m > AM_REL);
  endfunction

  function automatic logic needs_hi(input logic [MODE_W-1:0] m);
    return m inside {AM_ABS, AM_ABS_X, AM_ABS_Y, AM_IND};
  endfunction

  function automatic logic needs_zp_ptr(input logic [MODE_W-1:0] m);
    return m inside {AM_PRE_X, AM_POST_Y};
  endfunction

endpackage

// File: rtl/ares_step_fsm.sv
module ares_step_fsm
  import ares_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [MODE_W-1:0] mode_q,
  output step_e             step,
  output step_e             step_nxt
);

  always_comb begin
    step_nxt = step;
    unique case (step)
      ST_IDLE: if (start) step_nxt = no_read(mode_in) ? ST_FIN : ST_OPLO;
      ST_OPLO: begin
        if (needs_hi(mode_q))          step_nxt = ST_OPHI;
        else if (needs_zp_ptr(mode_q)) step_nxt = ST_PLO;
        else                           step_nxt = ST_FIN;
      end
      ST_OPHI: step_nxt = (mode_q == AM_IND) ? ST_PLO : ST_FIN;
      ST_PLO:  step_nxt = ST_PHI;
      ST_PHI:  step_nxt = ST_FIN;
      ST_FIN:  step_nxt = ST_IDLE;
      default: step_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= ST_IDLE;
    else        step <= step_nxt;
  end

endmodule

// File: rtl/ares_addr_mux.sv
module ares_addr_mux
  import ares_pkg::*;
(
  input  step_e             step,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [BYTE_W-1:0] x_q,
  input  logic [BYTE_W-1:0] y_q,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] ptr_lo,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] result,
  output logic              zp_ptr_rd,
  output logic              ind_hi_rd
);

  logic [BYTE_W-1:0] pre_ptr;
  assign pre_ptr = zp_wrap(op_lo, x_q);

  always_comb begin
    rd_en     = 1'b0;
    rd_addr   = '0;
    result    = '0;
    zp_ptr_rd = 1'b0;
    ind_hi_rd = 1'b0;
    unique case (step)
      ST_OPLO: begin
        rd_en   = 1'b1;
        rd_addr = pc_q;
        unique case (mode_q)
          AM_ZPG_X: result = in_page0(zp_wrap(rd_data, x_q));
          AM_ZPG_Y: result = in_page0(zp_wrap(rd_data, y_q));
          AM_REL:   result = rel_dest(pc_q + ADDR_W'(1), rd_data);
          default:  result = in_page0(rd_data);
        endcase
      end
      ST_OPHI: begin
        rd_en   = 1'b1;
        rd_addr = pc_q;
        unique case (mode_q)
          AM_ABS_X: result = idx_wide({rd_data, op_lo}, x_q);
          AM_ABS_Y: result = idx_wide({rd_data, op_lo}, y_q);
          default:  result = {rd_data, op_lo};
        endcase
      end
      ST_PLO: begin
        rd_en = 1'b1;
        unique case (mode_q)
          AM_PRE_X: begin rd_addr = in_page0(pre_ptr); zp_ptr_rd = 1'b1; end
          AM_POST_Y: begin rd_addr = in_page0(op_lo); zp_ptr_rd = 1'b1; end
          default:  rd_addr = {op_hi, op_lo};
        endcase
      end
      ST_PHI: begin
        rd_en = 1'b1;
        unique case (mode_q)
          AM_PRE_X: begin
            rd_addr   = in_page0(zp_wrap(pre_ptr, BYTE_W'(1)));
            zp_ptr_rd = 1'b1;
            result    = {rd_data, ptr_lo};
          end
          AM_POST_Y: begin
            rd_addr   = in_page0(zp_wrap(op_lo, BYTE_W'(1)));
            zp_ptr_rd = 1'b1;
            result    = idx_wide({rd_data, ptr_lo}, y_q);
          end
          default: begin
            rd_addr   = page_next({op_hi, op_lo});
            ind_hi_rd = 1'b1;
            result    = {rd_data, ptr_lo};
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import ares_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] pc_out,
  output logic              done
);

  step_e             step, step_nxt;
  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] pc_q, ea_q, result;
  logic [BYTE_W-1:0] x_q, y_q, op_lo, op_hi, ptr_lo;

  // named internal events for the checker
  logic in_idle, accept, fetch_op, finish_ld, zp_ptr_rd, ind_hi_rd;

  assign in_idle   = (step == ST_IDLE);
  assign accept    = in_idle && start;
  assign fetch_op  = (step == ST_OPLO) || (step == ST_OPHI);
  assign finish_ld = rd_en && (step_nxt == ST_FIN);

  ares_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_in  (mode),
    .mode_q   (mode_q),
    .step     (step),
    .step_nxt (step_nxt)
  );

  ares_addr_mux u_mux (
    .step      (step),
    .mode_q    (mode_q),
    .pc_q      (pc_q),
    .x_q       (x_q),
    .y_q       (y_q),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .ptr_lo    (ptr_lo),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .result    (result),
    .zp_ptr_rd (zp_ptr_rd),
    .ind_hi_rd (ind_hi_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pc_q   <= '0;
      ea_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      op_lo  <= '0;
      op_hi  <= '0;
      ptr_lo <= '0;
    end else begin
      if (accept) begin
        mode_q <= mode;
        x_q    <= idx_x;
        y_q    <= idx_y;
        if (mode == AM_IMMED) begin
          ea_q <= pc_in;
          pc_q <= pc_in + ADDR_W'(1);
        end else begin
          pc_q <= pc_in;
          if (no_read(mode)) ea_q <= '0;
        end
      end
      if (fetch_op)           pc_q   <= pc_q + ADDR_W'(1);
      if (step == ST_OPLO)    op_lo  <= rd_data;
      if (step == ST_OPHI)    op_hi  <= rd_data;
      if (step == ST_PLO)     ptr_lo <= rd_data;
      if (finish_ld)          ea_q   <= result;
    end
  end

  assign ea     = ea_q;
  assign pc_out = pc_q;
  assign done   = (step == ST_FIN);

endmodule

// File: rtl/ares_chk.sv
module ares_chk #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [MW-1:0] mode,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] pc_out,
  input logic          done,
  input logic          in_idle,
  input logic          zp_ptr_rd,
  input logic          ind_hi_rd
);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_no_read_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);

  a_r10_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !rd_en);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !start) |=> ($stable(ea) && $stable(pc_out)));

  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !done) |=> !in_idle);

  // pointer bytes of both indexed indirect modes stay in page zero (R6, R7)
  a_r6_zp_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    zp_ptr_rd |-> (rd_addr[AW-1:BW] == '0));

  a_r8_same_page_high: assert property (@(posedge clk) disable iff (!rst_n)
    ind_hi_rd |-> ((rd_addr[AW-1:BW] == $past(rd_addr[AW-1:BW])) &&
                   (rd_addr[BW-1:0] == $past(rd_addr[BW-1:0]) + BW'(1))));

  a_r2_no_read_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start && ((mode < MW'(3)) || (mode > MW'(12)))) |=> done);

endmodule

bind addr_resolver ares_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode      (mode),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .ea        (ea),
  .pc_out    (pc_out),
  .done      (done),
  .in_idle   (in_idle),
  .zp_ptr_rd (zp_ptr_rd),
  .ind_hi_rd (ind_hi_rd)
);

// File: tb/sim_addr_resolver.sv
`timescale 1ns/1ps
module sim_addr_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  idx_x = '0;
  logic [7:0]  idx_y = '0;
  logic [7:0]  rd_data = '0;
  logic        rd_en, done;
  logic [15:0] rd_addr, ea, pc_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  addr_resolver u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .idx_x(idx_x), .idx_y(idx_y), .rd_data(rd_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .ea(ea), .pc_out(pc_out), .done(done)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [3:0]  md;
    logic [15:0] pc;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [31:0] dat;   // bytes returned, in read order from the top
    logic [2:0]  n;     // number of reads
    logic [63:0] ra;    // expected read addresses, in order from the top
    logic [15:0] exp_ea;
    logic [15:0] exp_pc;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{4'd2, 4'd0,  16'h1234, 8'h00, 8'h00, 32'h0, 3'd0, 64'h0, 16'h0000, 16'h1234}, // R2 implied
    '{4'd2, 4'd1,  16'h4000, 8'h11, 8'h22, 32'h0, 3'd0, 64'h0, 16'h0000, 16'h4000}, // R2 accumulator
    '{4'd3, 4'd2,  16'h8000, 8'h00, 8'h00, 32'h0, 3'd0, 64'h0, 16'h8000, 16'h8001}, // R3 immediate
    '{4'd4, 4'd3,  16'h8010, 8'h00, 8'h00, 32'h44000000, 3'd1,
      64'h8010_0000_0000_0000, 16'h0044, 16'h8011},                                  // R4 zero page
    '{4'd4, 4'd4,  16'h8020, 8'h20, 8'h00, 32'hF0000000, 3'd1,
      64'h8020_0000_0000_0000, 16'h0010, 16'h8021},                                  // R4 zp+X wraps
    '{4'd4, 4'd5,  16'h9000, 8'h00, 8'h05, 32'h30000000, 3'd1,
      64'h9000_0000_0000_0000, 16'h0035, 16'h9001},                                  // R4 zp+Y
    '{4'd5, 4'd6,  16'hA000, 8'h00, 8'h00, 32'h34120000, 3'd2,
      64'hA000_A001_0000_0000, 16'h1234, 16'hA002},                                  // R5 absolute
    '{4'd5, 4'd7,  16'hA100, 8'h10, 8'h00, 32'hF8120000, 3'd2,
      64'hA100_A101_0000_0000, 16'h1308, 16'hA102},                                  // R5 page carry
    '{4'd5, 4'd8,  16'hFFFE, 8'h00, 8'h02, 32'hFFFF0000, 3'd2,
      64'hFFFE_FFFF_0000_0000, 16'h0001, 16'h0000},                                  // R5 16-bit wrap
    '{4'd6, 4'd9,  16'h0600, 8'h04, 8'h00, 32'hFB785600, 3'd3,
      64'h0600_00FF_0000_0000, 16'h5678, 16'h0601},                                  // R6 pointer wraps
    '{4'd6, 4'd9,  16'h0610, 8'h02, 8'h00, 32'h10CDAB00, 3'd3,
      64'h0610_0012_0013_0000, 16'hABCD, 16'h0611},                                  // R6 plain
    '{4'd7, 4'd10, 16'h0700, 8'h00, 8'h10, 32'hFFF52000, 3'd3,
      64'h0700_00FF_0000_0000, 16'h2105, 16'h0701},                                  // R7 wrap + carry
    '{4'd8, 4'd11, 16'h0800, 8'h00, 8'h00, 32'hFF0200C0, 3'd4,
      64'h0800_0801_02FF_0200, 16'hC000, 16'h0802},                                  // R8 same page
    '{4'd8, 4'd11, 16'h0810, 8'h00, 8'h00, 32'h10033412, 3'd4,
      64'h0810_0811_0310_0311, 16'h1234, 16'h0812},                                  // R8 plain
    '{4'd9, 4'd12, 16'h0900, 8'h00, 8'h00, 32'hFE000000, 3'd1,
      64'h0900_0000_0000_0000, 16'h08FF, 16'h0901},                                  // R9 backward
    '{4'd9, 4'd12, 16'h0A00, 8'h00, 8'h00, 32'h7F000000, 3'd1,
      64'h0A00_0000_0000_0000, 16'h0A80, 16'h0A01},                                  // R9 forward
    '{4'd9, 4'd12, 16'hFFFF, 8'h00, 8'h00, 32'h05000000, 3'd1,
      64'hFFFF_0000_0000_0000, 16'h0005, 16'h0000},                                  // R9 wrap
    '{4'd2, 4'd14, 16'h5555, 8'h00, 8'h00, 32'h0, 3'd0, 64'h0, 16'h0000, 16'h5555}  // R2 spare code
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, input bit keep_start);
    int nr;
    int cyc;
    @(negedge clk);
    start = 1'b1; mode = v.md; pc_in = v.pc; idx_x = v.x; idx_y = v.y;
    @(negedge clk);
    if (!keep_start) start = 1'b0;
    mode = 4'd2; pc_in = 16'h1111; idx_x = 8'hEE; idx_y = 8'hDD;
    nr = 0;
    cyc = 1;
    while (!done && cyc < 12) begin
      if (rd_en) begin
        if (nr < 4) begin
          chk({tag, " read addr"}, rd_addr, v.ra[63-16*nr -: 16]);
          rd_data = v.dat[31-8*nr -: 8];
        end
        nr++;
      end
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R10 done"}, {15'd0, done}, 16'd1);
    chk({tag, " R10 latency"}, 16'(cyc), 16'(v.n) + 16'd1);
    chk({tag, " R10 reads"}, 16'(nr), 16'(v.n));
    chk({tag, " R10 no read at done"}, {15'd0, rd_en}, 16'd0);
    chk({tag, " ea"}, ea, v.exp_ea);
    chk({tag, " pc"}, pc_out, v.exp_pc);
    @(negedge clk);
    chk({tag, " R10 done drops"}, {15'd0, done}, 16'd0);
    if (keep_start) begin
      chk({tag, " R11 start at done ignored"}, {15'd0, rd_en}, 16'd0);
      chk({tag, " R11 ea kept"}, ea, v.exp_ea);
      chk({tag, " R11 pc kept"}, pc_out, v.exp_pc);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ea in reset", ea, 16'h0000);
    chk("R1 pc in reset", pc_out, 16'h0000);
    chk("R1 done/rd_en in reset", {14'd0, done, rd_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {14'd0, done, rd_en}, 16'd0);
    chk("R1 ea after release", ea, 16'h0000);

    for (int i = 0; i < NV; i++)
      run_vec(VT[i], $sformatf("R%0d vec %0d", VT[i].rq, i), 1'b0);

    // R11: start held through reads and the done cycle (absolute indirect, wrap case)
    run_vec(VT[12], "R11 held start", 1'b1);

    // R11: outputs hold while idle and inputs move
    run_vec(VT[7], "R11 base", 1'b0);
    for (int k = 0; k < 5; k++) begin
      pc_in = 16'(k * 16'h1357); idx_x = 8'(k); mode = 4'(k);
      @(negedge clk);
    end
    chk("R11 ea held idle", ea, VT[7].exp_ea);
    chk("R11 pc held idle", pc_out, VT[7].exp_pc);
    chk("R11 no read idle", {15'd0, rd_en}, 16'd0);

    // R10: back-to-back requests
    run_vec(VT[9], "R10 back-to-back a", 1'b0);
    run_vec(VT[4], "R10 back-to-back b", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule